// File: doc/BRIEF.md
# Integrator Switch Sequencer

This block drives the per-channel analog switches of a charge-integrating front end through one scan. A rising edge on the reset strobe starts a reset phase. The block then counts readout-clock rising edges and opens the integrator reset switch, the reset-sample filter bypass and the internal reset window at fixed clock counts. Those counts depend on whether the readout runs in sequential or simultaneous mode.

The reset-sample and signal-sample strobes freeze their tracking switches. The integrate window gates the signal-sample filter bypass. The compensation strobe produces a one-cycle inject command on its falling edge and an opposite inject command on its rising edge. A reset-level select follows the integration polarity input.

All strobes, the readout clock and the mode inputs are sampled by a fast system clock. Every registered output moves on the second system-clock edge after its input changes.

Top module: `intg_switch_ctrl`

## Requirements
- R1: A reset-strobe rising edge closes the integrator reset switch and turns on the reset-sample track switch, the reset-sample filter bypass and the signal-sample track switch. It also clears the integration-active flag. Registered outputs change on the second system-clock edge after the input changes.
- R2: The integrator reset switch opens on the readout-clock falling edge that ends rising edge number 32 (sequential, `simul_mode`=0) or number 8 (simultaneous, `simul_mode`=1), counted from the reset edge.
- R3: The reset-sample filter bypass turns off on the readout-clock falling edge that ends clock 64 (sequential) or clock 16 (simultaneous).
- R4: A reset-sample strobe rising edge opens the reset-sample track switch. A signal-sample strobe rising edge opens the signal-sample track switch.
- R5: The signal-sample filter bypass is on while the integrate window is high and turns off when the window falls.
- R6: `rst_lvl_hi` is 0 (low reference) when `int_down` is 0 and 1 (high reference) when `int_down` is 1.
- R7: A compensation-strobe falling edge gives a one-cycle `comp_fwd` pulse. A rising edge gives a one-cycle `comp_rev` pulse. The two pulses are never high together.
- R8: `int_active` rises on the readout-clock falling edge that ends clock 132 (sequential) or clock 32 (simultaneous). Counting then stops.
- R9: While `pdn_n` or `nap_n` is low, the outputs take the safe state: integrator reset switch closed, every other switch, bypass and pulse off, and `int_active` low. The clock count is cleared, so readout clocks after power returns change nothing until a new reset edge arrives.
- R10: A reset-strobe rising edge during a count restarts the count from zero.
- R11: The mode is captured at the reset edge. Changing `simul_mode` during a phase does not alter that phase's counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low block reset |
| pdn_n | input | 1 | Power-down, active low |
| nap_n | input | 1 | Nap, active low |
| simul_mode | input | 1 | 1 = simultaneous, 0 = sequential counts |
| int_down | input | 1 | Integration polarity, 1 = integrate down |
| rd_clk | input | 1 | Readout clock |
| rst_strb | input | 1 | Integrator reset strobe |
| rsmp_strb | input | 1 | Reset-sample strobe |
| ssmp_strb | input | 1 | Signal-sample strobe |
| intg_win | input | 1 | Integrate window |
| comp_strb | input | 1 | Charge-compensation strobe |
| sw_int_rst | output | 1 | Integrator reset switch closed |
| sw_rtrack | output | 1 | Reset-sample tracking |
| rbyp | output | 1 | Reset-sample filter bypassed |
| sw_strack | output | 1 | Signal-sample tracking |
| sbyp | output | 1 | Signal-sample filter bypassed |
| comp_fwd | output | 1 | Inject compensation charge (pulse) |
| comp_rev | output | 1 | Inject opposite charge (pulse) |
| rst_lvl_hi | output | 1 | Reset level select, 1 = high reference |
| int_active | output | 1 | Internal reset over, integrating |

## Verification
The bench walks through each threshold one clock short and then exactly on the count, in both modes. A counter that is off by one, or a design that acts on rising instead of falling readout edges, opens a switch a clock early or late. A phase restarted mid-count must hold the reset switch closed past the original 32nd clock; a design that ignores the restart opens it early. Flipping the mode mid-phase, power-down with readout clocks still running, and compensation strobes during nap expose designs that re-read the mode live, keep counting after power returns, or let pulses through in the safe state.

// File: rtl/intg_switch_ctrl.sv
module intg_switch_ctrl #(
  parameter int CNT_W        = 8,
  parameter int SEQ_RST_CLKS = 32,
  parameter int SIM_RST_CLKS = 8,
  parameter int SEQ_TRK_CLKS = 64,
  parameter int SIM_TRK_CLKS = 16,
  parameter int SEQ_END_CLKS = 132,
  parameter int SIM_END_CLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_n,
  input  logic nap_n,
  input  logic simul_mode,
  input  logic int_down,
  input  logic rd_clk,
  input  logic rst_strb,
  input  logic rsmp_strb,
  input  logic ssmp_strb,
  input  logic intg_win,
  input  logic comp_strb,
  output logic sw_int_rst,
  output logic sw_rtrack,
  output logic rbyp,
  output logic sw_strack,
  output logic sbyp,
  output logic comp_fwd,
  output logic comp_rev,
  output logic rst_lvl_hi,
  output logic int_active
);

  localparam int NIN = 9;
  localparam int I_PWR = 0, I_CLK = 1, I_RST = 2, I_RSMP = 3, I_SSMP = 4;
  localparam int I_WIN = 5, I_COMP = 6, I_SIM = 7, I_DOWN = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NIN-1:0] raw, s_q, d_q, rise, fall;
  logic [CNT_W-1:0] cnt, lim_rst, lim_trk, lim_end;
  logic busy, mode_q;

  assign raw  = {int_down, simul_mode, comp_strb, intg_win, ssmp_strb,
                 rsmp_strb, rst_strb, rd_clk, pdn_n & nap_n};
  assign rise = s_q & ~d_q;
  assign fall = ~s_q & d_q;

  assign lim_rst = mode_q ? CNT_W'(SIM_RST_CLKS) : CNT_W'(SEQ_RST_CLKS);
  assign lim_trk = mode_q ? CNT_W'(SIM_TRK_CLKS) : CNT_W'(SEQ_TRK_CLKS);
  assign lim_end = mode_q ? CNT_W'(SIM_END_CLKS) : CNT_W'(SEQ_END_CLKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q        <= '0;
      d_q        <= '0;
      cnt        <= '0;
      busy       <= 1'b0;
      mode_q     <= 1'b0;
      sw_int_rst <= 1'b1;
      sw_rtrack  <= 1'b0;
      rbyp       <= 1'b0;
      sw_strack  <= 1'b0;
      sbyp       <= 1'b0;
      comp_fwd   <= 1'b0;
      comp_rev   <= 1'b0;
      rst_lvl_hi <= 1'b0;
      int_active <= 1'b0;
    end else begin
      s_q        <= raw;
      d_q        <= s_q;
      rst_lvl_hi <= s_q[I_DOWN];
      comp_fwd   <= 1'b0;
      comp_rev   <= 1'b0;
      if (!s_q[I_PWR]) begin
        cnt        <= '0;
        busy       <= 1'b0;
        sw_int_rst <= 1'b1;
        sw_rtrack  <= 1'b0;
        rbyp       <= 1'b0;
        sw_strack  <= 1'b0;
        sbyp       <= 1'b0;
        int_active <= 1'b0;
      end else begin
        sbyp     <= s_q[I_WIN];
        comp_fwd <= fall[I_COMP];
        comp_rev <= rise[I_COMP];
        if (rise[I_RST]) begin
          cnt        <= '0;
          busy       <= 1'b1;
          mode_q     <= s_q[I_SIM];
          sw_int_rst <= 1'b1;
          sw_rtrack  <= 1'b1;
          rbyp       <= 1'b1;
          sw_strack  <= 1'b1;
          int_active <= 1'b0;
        end else begin
          if (rise[I_RSMP]) sw_rtrack <= 1'b0;
          if (rise[I_SSMP]) sw_strack <= 1'b0;
          if (busy && rise[I_CLK] && cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (busy && fall[I_CLK]) begin
            if (cnt == lim_rst) sw_int_rst <= 1'b0;
            if (cnt == lim_trk) rbyp <= 1'b0;
            if (cnt == lim_end) begin
              int_active <= 1'b1;
              busy       <= 1'b0;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/intg_switch_ctrl_chk.sv
module intg_switch_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pdn_n,
  input logic nap_n,
  input logic intg_win,
  input logic int_down,
  input logic rst_strb,
  input logic sw_int_rst,
  input logic sw_rtrack,
  input logic rbyp,
  input logic sw_strack,
  input logic sbyp,
  input logic comp_fwd,
  input logic comp_rev,
  input logic rst_lvl_hi,
  input logic int_active
);
  logic [1:0] up;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up <= '0;
    else if (up != 2'd3) up <= up + 1'b1;

  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(comp_fwd && comp_rev));
  assert_pulse_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
    comp_fwd |=> !comp_fwd);
  assert_safe_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2 && !$past(pdn_n && nap_n, 2)) |->
      (sw_int_rst && !sw_rtrack && !rbyp && !sw_strack && !sbyp &&
       !int_active && !comp_fwd && !comp_rev));
  assert_sbyp_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2) |-> (sbyp == $past(intg_win && pdn_n && nap_n, 2)));
  assert_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2) |-> (rst_lvl_hi == $past(int_down, 2)));
  assert_active_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_active |-> (!sw_int_rst && !rbyp));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up == 2'd3 && $past(rst_strb, 2) && !$past(rst_strb, 3) &&
     $past(pdn_n && nap_n, 2)) |-> (sw_int_rst && rbyp && sw_rtrack && !int_active));
endmodule

bind intg_switch_ctrl intg_switch_ctrl_chk u_chk (.*);

// File: tb/test_intg_switch_ctrl.sv
module test_intg_switch_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, pdn_n = 1'b1, nap_n = 1'b1;
  logic simul_mode = 1'b0, int_down = 1'b0, rd_clk = 1'b0;
  logic rst_strb = 1'b0, rsmp_strb = 1'b0, ssmp_strb = 1'b0;
  logic intg_win = 1'b0, comp_strb = 1'b0;
  logic sw_int_rst, sw_rtrack, rbyp, sw_strack, sbyp;
  logic comp_fwd, comp_rev, rst_lvl_hi, int_active;

  always #2.5 clk = ~clk;

  intg_switch_ctrl i_intg_switch_ctrl (.*);

  typedef struct {
    logic [6:0] vec;
    int fwd;
    int rev;
    string req;
  } exp_t;
  exp_t q[$];
  int total = 0, bad = 0, nfwd = 0, nrev = 0, efwd = 0, erev = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    logic [6:0] got;
    if (comp_fwd) nfwd++;
    if (comp_rev) nrev++;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      got = {sw_int_rst, sw_rtrack, rbyp, sw_strack, sbyp, int_active, rst_lvl_hi};
      total++;
      if (got !== e.vec || nfwd != e.fwd || nrev != e.rev) begin
        bad++;
        $display("FAIL %s: got vec=%b fwd=%0d rev=%0d, expected vec=%b fwd=%0d rev=%0d",
                 e.req, got, nfwd, nrev, e.vec, e.fwd, e.rev);
      end
    end
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_vec(input logic [6:0] v, input string req);
    exp_t e;
    e.vec = v; e.fwd = efwd; e.rev = erev; e.req = req;
    q.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rdclk(input int n);
    for (int i = 0; i < n; i++) begin
      rd_clk = 1'b1; repeat (2) @(negedge clk);
      rd_clk = 1'b0; repeat (2) @(negedge clk);
    end
    settle();
  endtask

  task automatic rst_pulse();
    rst_strb = 1'b1; repeat (2) @(negedge clk);
    rst_strb = 1'b0; settle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_vec(7'b1000000, "reset state R9");

    // sequential, integrate up
    rst_pulse();                 expect_vec(7'b1111000, "R1 phase start");
    rdclk(31);                   expect_vec(7'b1111000, "R2 clk31 seq");
    rdclk(1);                    expect_vec(7'b0111000, "R2 clk32 seq");
    rdclk(31);                   expect_vec(7'b0111000, "R3 clk63 seq");
    rdclk(1);                    expect_vec(7'b0101000, "R3 clk64 seq");
    rsmp_strb = 1'b1; settle(); rsmp_strb = 1'b0; settle();
                                 expect_vec(7'b0001000, "R4 reset sample hold");
    rdclk(67);                   expect_vec(7'b0001000, "R8 clk131 seq");
    rdclk(1);                    expect_vec(7'b0001010, "R8 clk132 seq");
    intg_win = 1'b1; settle();   expect_vec(7'b0001110, "R5 window high");
    intg_win = 1'b0; settle();   expect_vec(7'b0001010, "R5 window low");
    ssmp_strb = 1'b1; settle(); ssmp_strb = 1'b0; settle();
                                 expect_vec(7'b0000010, "R4 signal sample hold");
    comp_strb = 1'b1; settle(); erev = 1;
                                 expect_vec(7'b0000010, "R7 rising edge");
    comp_strb = 1'b0; settle(); efwd = 1;
                                 expect_vec(7'b0000010, "R7 falling edge");
    int_down = 1'b1; settle();   expect_vec(7'b0000011, "R6 integrate down");

    // simultaneous, mode changed mid-phase
    simul_mode = 1'b1;
    rst_pulse();                 expect_vec(7'b1111001, "R1 simul start");
    rdclk(4); simul_mode = 1'b0;
    rdclk(3);                    expect_vec(7'b1111001, "R2 R11 clk7 simul");
    rdclk(1);                    expect_vec(7'b0111001, "R2 R11 clk8 simul");
    rdclk(7);                    expect_vec(7'b0111001, "R3 clk15 simul");
    rdclk(1);                    expect_vec(7'b0101001, "R3 clk16 simul");
    rdclk(15);                   expect_vec(7'b0101001, "R8 clk31 simul");
    rdclk(1);                    expect_vec(7'b0101011, "R8 clk32 simul");

    // restart mid-count
    int_down = 1'b0;
    rst_pulse();                 expect_vec(7'b1111000, "R10 first start");
    rdclk(20);
    rst_pulse();                 expect_vec(7'b1111000, "R10 restart");
    rdclk(20);                   expect_vec(7'b1111000, "R10 clk40 overall");
    rdclk(12);                   expect_vec(7'b0111000, "R10 clk32 after restart");

    // power-down and nap
    pdn_n = 1'b0; settle();      expect_vec(7'b1000000, "R9 power-down safe");
    rdclk(40);                   expect_vec(7'b1000000, "R9 clocks while down");
    pdn_n = 1'b1; settle();
    rdclk(140);                  expect_vec(7'b1000000, "R9 count cleared");
    nap_n = 1'b0; intg_win = 1'b1; settle();
                                 expect_vec(7'b1000000, "R9 nap blocks bypass");
    comp_strb = 1'b1; settle(); comp_strb = 1'b0; settle();
                                 expect_vec(7'b1000000, "R9 nap blocks inject");
    nap_n = 1'b1; settle();      expect_vec(7'b1000100, "R5 window after nap");
    intg_win = 1'b0; settle();   expect_vec(7'b1000000, "R5 window drop");

    settle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule